// File: doc/BRIEF.md
# Memory Test Mode Sequencer

This block decides the order of block transfers for one channel of a memory tester. It drives two engines, one that writes a region and one that reads a region back. Each engine receives a one-cycle start command with a base offset and a size, and returns a one-cycle done pulse when the block is finished. A write block counts as done when the response for its last burst has been accepted. A read block counts as done when the final beat of its last burst has been accepted. The engines themselves are outside this block.

Four modes are supported. The first writes the block repeatedly. The second reads it repeatedly. The third writes one half of the region while reading the other half at the same time. The fourth alternates a full write with a full read. Both modes that read first fill the region they will read in a single preparatory write pass, unless the fill is disabled. When the test duration runs out, the sequencer never cuts a block short. Every engine finishes the block it is working on, and only then is the test reported as done.

Top module: `mts_sequencer`

## Requirements
- R1: After reset the status output reads 0 (idle), `test_done_o` is low, both enables are low and no start command is issued. The status codes are 0 idle, 1 prewrite, 2 write run, 3 read run, 4 simultaneous run, 5 drain and 6 done. No other code appears.
- R2: Mode code 0 (write-only) issues write commands for the full region (`base`, `len`) again and again. After expiry it stops at the end of the current block.
- R3: Mode code 1 (read-only) first issues one full-region write with status 1. It then issues full-region reads repeatedly.
- R4: Mode code 2 (simultaneous) uses half = len/2, rounded down. It writes base with size half. It reads base+half with size len−half. The preparatory pass writes only base+half with size len−half, and reports status 1 while it runs.
- R5: Mode code 3 (alternate) issues a full write and then a full read, over and over, and the two engines are never enabled at the same time. After expiry the test ends only once a read block has completed.
- R6: When `no_prewrite_i` is high at start, modes 1 and 2 skip the preparatory pass and begin with their run commands.
- R7: Expiry during a block neither ends the test nor aborts the block. `test_done_o` rises only in the cycle after a done pulse. No further command is issued after the final block.
- R8: In mode 2 after expiry, each engine stops at its own block end. While one engine is still busy the status is 5, and the test is done only after both engines have finished.
- R9: An expiry during the preparatory pass still lets one full read block run before the test is done.
- R10: A start command is a one-cycle pulse in the cycle after its trigger is sampled. The matching enable is high from that cycle until the cycle after the block's done pulse, and the command's base and size stay steady while the enable is high. Status 6 holds until the next start.
- R11: Mode, base, length and prewrite control are captured when a start is accepted, which happens only at status 0 or 6. A start pulse or a change to those inputs while a test is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a test (accepted at idle or done) |
| mode_i | input | 2 | 0 write-only, 1 read-only, 2 simultaneous, 3 alternate |
| base_i | input | ADDR_W | Region base offset |
| len_i | input | ADDR_W | Region length |
| no_prewrite_i | input | 1 | Skip the preparatory fill pass |
| expired_i | input | 1 | Test duration has elapsed |
| wr_done_i | input | 1 | Write engine finished its block |
| rd_done_i | input | 1 | Read engine finished its block |
| wr_start_o | output | 1 | Start pulse to write engine |
| wr_base_o | output | ADDR_W | Write block base |
| wr_size_o | output | ADDR_W | Write block size |
| wr_en_o | output | 1 | Write engine has a block in flight |
| rd_start_o | output | 1 | Start pulse to read engine |
| rd_base_o | output | ADDR_W | Read block base |
| rd_size_o | output | ADDR_W | Read block size |
| rd_en_o | output | 1 | Read engine has a block in flight |
| test_done_o | output | 1 | Test finished |
| state_o | output | 3 | Current status code |

## Verification
The drain case in simultaneous mode is the hardest to reach. It needs expiry to arrive while both engines are busy, and the two engines must then finish at different times. The bench gives its engine models different latencies (4 and 9 cycles), so the write engine restarts several times during one read block. Expiry is raised during the second read block. The bench then waits for the write enable to drop and checks that the status shows drain while the read is still open. For the alternate case, expiry is placed inside a write block, so that the trailing read block has to be observed before the test reports done.

// File: rtl/mts_pkg.sv
package mts_pkg;

    typedef enum logic [1:0] {
        MODE_WR    = 2'd0,
        MODE_RD    = 2'd1,
        MODE_SIMUL = 2'd2,
        MODE_ALT   = 2'd3
    } mts_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_PREWRITE  = 3'd1,
        ST_RUN_WR    = 3'd2,
        ST_RUN_RD    = 3'd3,
        ST_RUN_SIMUL = 3'd4,
        ST_DRAIN     = 3'd5,
        ST_DONE      = 3'd6
    } mts_state_e;

    typedef enum logic [1:0] {
        REG_FULL = 2'd0,
        REG_LOW  = 2'd1,
        REG_HIGH = 2'd2
    } mts_region_e;

    typedef struct packed {
        logic        go;
        mts_region_e region;
    } mts_launch_t;

    function automatic logic mts_at_rest(mts_state_e s);
        return (s == ST_IDLE) || (s == ST_DONE);
    endfunction

endpackage

// File: rtl/mts_region.sv
module mts_region
    import mts_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] len_i,
    input  mts_region_e       region_i,
    output logic [ADDR_W-1:0] base_o,
    output logic [ADDR_W-1:0] size_o
);
    logic [ADDR_W-1:0] half;

    always_comb begin
        half = len_i >> 1;
        case (region_i)
            REG_LOW: begin
                base_o = base_i;
                size_o = half;
            end
            REG_HIGH: begin
                base_o = base_i + half;
                size_o = len_i - half;
            end
            default: begin
                base_o = base_i;
                size_o = len_i;
            end
        endcase
    end
endmodule

// File: rtl/mts_ctrl.sv
module mts_ctrl
    import mts_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  mts_mode_e   mode_i,
    input  logic        no_prewrite_i,
    input  logic        expired_i,
    input  logic        wr_done_i,
    input  logic        rd_done_i,
    output mts_launch_t wr_launch_o,
    output mts_launch_t rd_launch_o,
    output logic        wr_busy_o,
    output logic        rd_busy_o,
    output logic        accept_o,
    output mts_state_e  state_o
);
    mts_state_e  st_q, st_n;
    mts_mode_e   mode_q, mode_n;
    mts_region_e wsel_q, wsel_n, rsel_q, rsel_n;
    logic        wgo, rgo, exp_q, exp_any, w_left, r_left;
    logic        wgo_q, rgo_q, wbusy_q, rbusy_q;

    assign accept_o = start_i && mts_at_rest(st_q);
    assign exp_any  = expired_i || exp_q;
    assign w_left   = wbusy_q && !wr_done_i;
    assign r_left   = rbusy_q && !rd_done_i;

    always_comb begin
        st_n   = st_q;
        mode_n = mode_q;
        wsel_n = wsel_q;
        rsel_n = rsel_q;
        wgo    = 1'b0;
        rgo    = 1'b0;
        case (st_q)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    mode_n = mode_i;
                    case (mode_i)
                        MODE_WR, MODE_ALT: begin
                            st_n = ST_RUN_WR; wgo = 1'b1; wsel_n = REG_FULL;
                        end
                        MODE_RD: begin
                            if (no_prewrite_i) begin
                                st_n = ST_RUN_RD; rgo = 1'b1; rsel_n = REG_FULL;
                            end else begin
                                st_n = ST_PREWRITE; wgo = 1'b1; wsel_n = REG_FULL;
                            end
                        end
                        MODE_SIMUL: begin
                            if (no_prewrite_i) begin
                                st_n = ST_RUN_SIMUL;
                                wgo = 1'b1; wsel_n = REG_LOW;
                                rgo = 1'b1; rsel_n = REG_HIGH;
                            end else begin
                                st_n = ST_PREWRITE; wgo = 1'b1; wsel_n = REG_HIGH;
                            end
                        end
                    endcase
                end
            end
            ST_PREWRITE: begin
                if (wr_done_i) begin
                    if (mode_q == MODE_SIMUL) begin
                        st_n = ST_RUN_SIMUL;
                        wgo = 1'b1; wsel_n = REG_LOW;
                        rgo = 1'b1; rsel_n = REG_HIGH;
                    end else begin
                        st_n = ST_RUN_RD; rgo = 1'b1; rsel_n = REG_FULL;
                    end
                end
            end
            ST_RUN_WR: begin
                if (wr_done_i) begin
                    if (mode_q == MODE_ALT) begin
                        st_n = ST_RUN_RD; rgo = 1'b1; rsel_n = REG_FULL;
                    end else if (exp_any) begin
                        st_n = ST_DONE;
                    end else begin
                        wgo = 1'b1;
                    end
                end
            end
            ST_RUN_RD: begin
                if (rd_done_i) begin
                    if (exp_any) begin
                        st_n = ST_DONE;
                    end else if (mode_q == MODE_ALT) begin
                        st_n = ST_RUN_WR; wgo = 1'b1; wsel_n = REG_FULL;
                    end else begin
                        rgo = 1'b1;
                    end
                end
            end
            ST_RUN_SIMUL: begin
                if (exp_any) begin
                    st_n = (w_left || r_left) ? ST_DRAIN : ST_DONE;
                end else begin
                    wgo = wr_done_i;
                    rgo = rd_done_i;
                end
            end
            ST_DRAIN: begin
                if (!w_left && !r_left) st_n = ST_DONE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            mode_q  <= MODE_WR;
            wsel_q  <= REG_FULL;
            rsel_q  <= REG_FULL;
            wgo_q   <= 1'b0;
            rgo_q   <= 1'b0;
            wbusy_q <= 1'b0;
            rbusy_q <= 1'b0;
            exp_q   <= 1'b0;
        end else begin
            st_q    <= st_n;
            mode_q  <= mode_n;
            wsel_q  <= wsel_n;
            rsel_q  <= rsel_n;
            wgo_q   <= wgo;
            rgo_q   <= rgo;
            wbusy_q <= wgo || w_left;
            rbusy_q <= rgo || r_left;
            exp_q   <= accept_o ? 1'b0 : (exp_q || (expired_i && !mts_at_rest(st_q)));
        end
    end

    assign wr_launch_o = '{go: wgo_q, region: wsel_q};
    assign rd_launch_o = '{go: rgo_q, region: rsel_q};
    assign wr_busy_o   = wbusy_q;
    assign rd_busy_o   = rbusy_q;
    assign state_o     = st_q;
endmodule

// File: rtl/mts_sequencer.sv
module mts_sequencer
    import mts_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] len_i,
    input  logic              no_prewrite_i,
    input  logic              expired_i,
    input  logic              wr_done_i,
    input  logic              rd_done_i,
    output logic              wr_start_o,
    output logic [ADDR_W-1:0] wr_base_o,
    output logic [ADDR_W-1:0] wr_size_o,
    output logic              wr_en_o,
    output logic              rd_start_o,
    output logic [ADDR_W-1:0] rd_base_o,
    output logic [ADDR_W-1:0] rd_size_o,
    output logic              rd_en_o,
    output logic              test_done_o,
    output logic [2:0]        state_o
);
    localparam int NUM_ENG = 2;

    mts_launch_t       wr_launch, rd_launch;
    mts_state_e        state;
    logic              accept;
    logic [ADDR_W-1:0] base_q, len_q;
    mts_region_e       sel   [NUM_ENG];
    logic [ADDR_W-1:0] cbase [NUM_ENG];
    logic [ADDR_W-1:0] csize [NUM_ENG];

    mts_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .mode_i       (mts_mode_e'(mode_i)),
        .no_prewrite_i(no_prewrite_i),
        .expired_i    (expired_i),
        .wr_done_i    (wr_done_i),
        .rd_done_i    (rd_done_i),
        .wr_launch_o  (wr_launch),
        .rd_launch_o  (rd_launch),
        .wr_busy_o    (wr_en_o),
        .rd_busy_o    (rd_en_o),
        .accept_o     (accept),
        .state_o      (state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            len_q  <= '0;
        end else if (accept) begin
            base_q <= base_i;
            len_q  <= len_i;
        end
    end

    always_comb begin
        sel[0] = wr_launch.region;
        sel[1] = rd_launch.region;
    end

    for (genvar g = 0; g < NUM_ENG; g++) begin : g_region
        mts_region #(.ADDR_W(ADDR_W)) u_region (
            .base_i  (base_q),
            .len_i   (len_q),
            .region_i(sel[g]),
            .base_o  (cbase[g]),
            .size_o  (csize[g])
        );
    end

    assign wr_start_o  = wr_launch.go;
    assign rd_start_o  = rd_launch.go;
    assign wr_base_o   = cbase[0];
    assign wr_size_o   = csize[0];
    assign rd_base_o   = cbase[1];
    assign rd_size_o   = csize[1];
    assign test_done_o = (state == ST_DONE);
    assign state_o     = state;
endmodule

// File: rtl/mts_sequencer_chk.sv
module mts_sequencer_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_done_i,
    input logic              rd_done_i,
    input logic              wr_start_o,
    input logic [ADDR_W-1:0] wr_base_o,
    input logic [ADDR_W-1:0] wr_size_o,
    input logic              wr_en_o,
    input logic              rd_start_o,
    input logic [ADDR_W-1:0] rd_base_o,
    input logic [ADDR_W-1:0] rd_size_o,
    input logic              rd_en_o,
    input logic              test_done_o,
    input logic [2:0]        state_o
);
    assert_status_legal_R1: assert property (@(posedge clk) disable iff (rst)
        state_o <= 3'd6);

    assert_done_after_block_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(test_done_o) |-> $past(wr_done_i || rd_done_i));

    assert_quiet_when_done_R7: assert property (@(posedge clk) disable iff (rst)
        test_done_o |-> !wr_start_o && !rd_start_o && !wr_en_o && !rd_en_o);

    assert_drain_has_work_R8: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd5) |-> (wr_en_o || rd_en_o));

    assert_wr_start_enabled_R10: assert property (@(posedge clk) disable iff (rst)
        wr_start_o |-> wr_en_o);

    assert_rd_start_enabled_R10: assert property (@(posedge clk) disable iff (rst)
        rd_start_o |-> rd_en_o);

    assert_wr_cmd_steady_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en_o && !wr_start_o) |-> ($stable(wr_base_o) && $stable(wr_size_o)));

    assert_rd_cmd_steady_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_en_o && !rd_start_o) |-> ($stable(rd_base_o) && $stable(rd_size_o)));
endmodule

bind mts_sequencer mts_sequencer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_done_i  (wr_done_i),
    .rd_done_i  (rd_done_i),
    .wr_start_o (wr_start_o),
    .wr_base_o  (wr_base_o),
    .wr_size_o  (wr_size_o),
    .wr_en_o    (wr_en_o),
    .rd_start_o (rd_start_o),
    .rd_base_o  (rd_base_o),
    .rd_size_o  (rd_size_o),
    .rd_en_o    (rd_en_o),
    .test_done_o(test_done_o),
    .state_o    (state_o)
);

// File: tb/mts_sequencer_tb.sv
module mts_sequencer_tb;
    localparam int AW = 32;
    localparam int WATCHDOG = 100000;

    logic          clk = 1'b0;
    logic          rst;
    logic          start_i, no_prewrite_i, expired_i;
    logic [1:0]    mode_i;
    logic [AW-1:0] base_i, len_i;
    logic          wr_done_i, rd_done_i;
    logic          wr_start_o, rd_start_o, wr_en_o, rd_en_o, test_done_o;
    logic [AW-1:0] wr_base_o, wr_size_o, rd_base_o, rd_size_o;
    logic [2:0]    state_o;

    always #4 clk = ~clk;

    mts_sequencer #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
        .base_i(base_i), .len_i(len_i), .no_prewrite_i(no_prewrite_i),
        .expired_i(expired_i), .wr_done_i(wr_done_i), .rd_done_i(rd_done_i),
        .wr_start_o(wr_start_o), .wr_base_o(wr_base_o), .wr_size_o(wr_size_o),
        .wr_en_o(wr_en_o), .rd_start_o(rd_start_o), .rd_base_o(rd_base_o),
        .rd_size_o(rd_size_o), .rd_en_o(rd_en_o), .test_done_o(test_done_o),
        .state_o(state_o)
    );

    // engine models: finish a block a fixed number of cycles after its start
    int wlat = 4, rlat = 4;
    int wcnt, rcnt;
    always @(negedge clk) begin
        wr_done_i = 1'b0;
        rd_done_i = 1'b0;
        if (rst) begin
            wcnt = 0;
            rcnt = 0;
        end else begin
            if (wr_start_o) wcnt = wlat;
            else if (wcnt > 0) begin
                wcnt--;
                if (wcnt == 0) wr_done_i = 1'b1;
            end
            if (rd_start_o) rcnt = rlat;
            else if (rcnt > 0) begin
                rcnt--;
                if (rcnt == 0) rd_done_i = 1'b1;
            end
        end
    end

    int checks = 0, errors = 0, cycles = 0;
    int nwr = 0, nrd = 0, overlap = 0;
    int wr0, rd0, ov0;
    string cur_req = "R1";
    logic [63:0] exp_wr[$];
    logic [63:0] exp_rd[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic summary_and_end();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // monitor: pops expected commands as the design issues them
    task automatic monitor();
        logic [63:0] e;
        forever begin
            @(negedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                chk(1'b0, cur_req, "watchdog", cycles, WATCHDOG);
                summary_and_end();
            end
            if (!rst) begin
                if (wr_start_o) begin
                    nwr++;
                    if (exp_wr.size() == 0) chk(1'b0, cur_req, "unexpected write cmd", {wr_base_o, wr_size_o}, 0);
                    else begin
                        e = exp_wr.pop_front();
                        chk({wr_base_o, wr_size_o} == e, cur_req, "write cmd base:size", {wr_base_o, wr_size_o}, e);
                    end
                end
                if (rd_start_o) begin
                    nrd++;
                    if (exp_rd.size() == 0) chk(1'b0, cur_req, "unexpected read cmd", {rd_base_o, rd_size_o}, 0);
                    else begin
                        e = exp_rd.pop_front();
                        chk({rd_base_o, rd_size_o} == e, cur_req, "read cmd base:size", {rd_base_o, rd_size_o}, e);
                    end
                end
                if (wr_en_o && rd_en_o) overlap++;
            end
        end
    endtask

    task automatic push_wr(input int b, input int s, input int n);
        for (int i = 0; i < n; i++) exp_wr.push_back({b[AW-1:0], s[AW-1:0]});
    endtask

    task automatic push_rd(input int b, input int s, input int n);
        for (int i = 0; i < n; i++) exp_rd.push_back({b[AW-1:0], s[AW-1:0]});
    endtask

    task automatic kick(input int m, input bit np, input int b, input int l);
        @(negedge clk);
        wr0 = nwr; rd0 = nrd; ov0 = overlap;
        expired_i = 1'b0;
        mode_i = m[1:0]; no_prewrite_i = np; base_i = b[AW-1:0]; len_i = l[AW-1:0];
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_wr(input int n);
        while (nwr - wr0 < n) @(negedge clk);
    endtask

    task automatic wait_rd(input int n);
        while (nrd - rd0 < n) @(negedge clk);
    endtask

    task automatic wait_done();
        while (!test_done_o) @(negedge clk);
    endtask

    task automatic check_empty(input string req);
        chk(exp_wr.size() == 0, req, "pending write cmds", exp_wr.size(), 0);
        chk(exp_rd.size() == 0, req, "pending read cmds", exp_rd.size(), 0);
    endtask

    initial begin
        rst = 1'b1; start_i = 1'b0; mode_i = 2'd0; base_i = '0; len_i = '0;
        no_prewrite_i = 1'b0; expired_i = 1'b0;
        fork
            monitor();
        join_none
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1: reset state
        chk(state_o == 3'd0, "R1", "status", state_o, 0);
        chk(!test_done_o, "R1", "test_done", test_done_o, 0);
        chk(!wr_en_o && !rd_en_o, "R1", "enables", {wr_en_o, rd_en_o}, 0);
        chk(nwr == 0 && nrd == 0, "R1", "commands", nwr + nrd, 0);

        // R2 + R11 + R7: write-only, restart attempt ignored, expiry mid-block
        cur_req = "R2"; wlat = 5;
        push_wr('h100, 'h40, 3);
        kick(0, 0, 'h100, 'h40);
        wait_wr(1);
        mode_i = 2'd1; base_i = 'h999; len_i = 'h8; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(state_o == 3'd2, "R11", "status after ignored start", state_o, 2);
        wait_wr(3);
        expired_i = 1'b1;
        @(negedge clk);
        chk(state_o == 3'd2 && !test_done_o, "R7", "still running after expiry", state_o, 2);
        chk(wr_en_o, "R7", "block not aborted", wr_en_o, 1);
        wait_done();
        chk(state_o == 3'd6, "R10", "done status", state_o, 6);
        chk(!wr_en_o, "R10", "write enable after last block", wr_en_o, 0);
        check_empty("R2");
        repeat (8) @(negedge clk);
        chk(nwr - wr0 == 3, "R7", "no command after final block", nwr - wr0, 3);
        chk(state_o == 3'd6, "R10", "done holds", state_o, 6);

        // R3: read-only with prewrite
        cur_req = "R3"; wlat = 3; rlat = 4;
        push_wr('h200, 'h80, 1);
        push_rd('h200, 'h80, 3);
        kick(1, 0, 'h200, 'h80);
        wait_wr(1);
        chk(state_o == 3'd1, "R3", "prewrite status", state_o, 1);
        wait_rd(3);
        expired_i = 1'b1;
        wait_done();
        check_empty("R3");
        chk(nwr - wr0 == 1, "R3", "single prewrite", nwr - wr0, 1);

        // R6: read-only without prewrite
        cur_req = "R6";
        push_rd('h400, 'h20, 2);
        kick(1, 1, 'h400, 'h20);
        wait_rd(1);
        chk(state_o == 3'd3, "R6", "read run status", state_o, 3);
        wait_rd(2);
        expired_i = 1'b1;
        wait_done();
        check_empty("R6");
        chk(nwr - wr0 == 0, "R6", "no write issued", nwr - wr0, 0);

        // R4 + R8: simultaneous with prewrite, odd length, drain
        cur_req = "R4"; wlat = 4; rlat = 9;
        push_wr('h1080, 'h81, 1);
        push_wr('h1000, 'h80, 3);
        push_rd('h1080, 'h81, 2);
        kick(2, 0, 'h1000, 'h101);
        wait_wr(1);
        chk(state_o == 3'd1, "R4", "prewrite status", state_o, 1);
        wait_rd(1);
        chk(state_o == 3'd4, "R4", "simultaneous status", state_o, 4);
        wait_rd(2);
        expired_i = 1'b1;
        cur_req = "R8";
        while (wr_en_o) @(negedge clk);
        chk(state_o == 3'd5, "R8", "drain status", state_o, 5);
        chk(rd_en_o && !test_done_o, "R8", "read still open", {rd_en_o, test_done_o}, 2);
        wait_done();
        check_empty("R8");
        chk(nwr - wr0 == 4, "R8", "write blocks", nwr - wr0, 4);
        chk(nrd - rd0 == 2, "R8", "read blocks", nrd - rd0, 2);

        // R6 + R4: simultaneous without prewrite, both end together
        cur_req = "R6"; wlat = 3; rlat = 3;
        push_wr('h0, 'h20, 1);
        push_rd('h20, 'h20, 1);
        kick(2, 1, 'h0, 'h40);
        wait_wr(1);
        expired_i = 1'b1;
        wait_done();
        check_empty("R6");
        chk(state_o == 3'd6, "R4", "done after both blocks", state_o, 6);

        // R5: alternate, expiry during a write block
        cur_req = "R5"; wlat = 2; rlat = 3;
        push_wr('h300, 'h10, 2);
        push_rd('h300, 'h10, 2);
        kick(3, 0, 'h300, 'h10);
        wait_wr(2);
        expired_i = 1'b1;
        wait_done();
        check_empty("R5");
        chk(nrd - rd0 == 2, "R5", "ends after a read block", nrd - rd0, 2);
        chk(overlap - ov0 == 0, "R5", "engines never both enabled", overlap - ov0, 0);

        // R9: expiry during the preparatory pass
        cur_req = "R9"; wlat = 5; rlat = 2;
        push_wr('h40, 'h40, 1);
        push_rd('h40, 'h40, 1);
        kick(1, 0, 'h40, 'h40);
        wait_wr(1);
        expired_i = 1'b1;
        wait_done();
        check_empty("R9");
        chk(nrd - rd0 == 1, "R9", "one read after prewrite", nrd - rd0, 1);

        repeat (5) @(negedge clk);
        summary_and_end();
    end
endmodule